// File: doc/BRIEF.md
# Configurable Serial Line Port

This block is a byte-oriented serial port with a run-time selectable line mode. In the two line-coded modes it sends each byte as differential Manchester bit cells and decodes differential Manchester cells arriving on the receive side back into bytes. The single-ended line-coded mode drives one transmit line and an enable for an external transceiver. The differential line-coded mode drives a complementary output pair and reads a receive pair.

In pass-through mode the port does no line coding. It shifts raw NRZ bits out and gives an external line-coding device a bit clock and a frame clock. It takes raw bits back and uses a receive frame marker from that device to find where each byte starts.

Each byte is sent as its own frame of `DATA_BITS + 2` bit cells: one quiet lead cell, the data cells with the most significant bit first, and one quiet trail cell. A cell lasts `CELL_CYCLES` clock cycles. `CELL_CYCLES` must be a multiple of four and at least 8. Bytes enter on a valid/ready stream. Decoded bytes leave on a valid/ready stream whose holding register keeps only the newest byte.

Top module: `linePort`

## Requirements
- R1: `cfgMode` selects the line mode. Value 0 is single-ended line-coded, value 1 is pass-through, and values 2 and 3 are both differential line-coded. The mode after reset is single-ended.
- R2: In the line-coded modes the coded line level changes in the first cycle of every data cell. A 0 bit adds a second change at cycle `CELL_CYCLES/2` of its cell, and a 1 bit adds none. Bits go out MSB first. The level holds steady in the lead cell, in the trail cell and between frames.
- R3: A byte is taken at a clock edge where `txValid` and `txReady` are both high. `txReady` then stays low for `(DATA_BITS+2)*CELL_CYCLES` cycles. Data cell i (i = 0 for the MSB) begins `CELL_CYCLES*(1+i)` cycles after the accepting edge. After reset `txReady` is high and `lineTx` is low.
- R4: In single-ended mode, `txEnable` is high from the first cycle of the lead cell to the last cycle of the trail cell and low otherwise. `lineTxN` stays low.
- R5: In differential mode, `lineTxN` is always the complement of `lineTx`, and `txEnable` stays low.
- R6: In pass-through mode, `lineTx` carries the current bit during data cells and is low otherwise. `bitClk` is high in the first half of each data cell. `frameClk` is high for the whole first data cell. `txEnable` and `lineTxN` stay low. The line-coded level is left unchanged by pass-through frames.
- R7: In the line-coded modes the receiver decodes differential Manchester cells into bytes, MSB first, and presents each byte on `rxData` with `rxValid`. In differential mode the received bit is `lineRx` while the pair differs.
- R8: In pass-through mode a rising edge on `lineRxN` (used as the receive frame marker) starts a byte. Each of the following bits is sampled from `lineRx` at the middle of its cell.
- R9: If a line-coded cell boundary change does not arrive within `CELL_CYCLES/4` cycles after it was due, `codeViolation` pulses for one cycle. The partial byte is discarded and the receiver waits for the next change.
- R10: `rxValid` stays high until a cycle with `rxReady` high. A byte completed while the previous one is still unread replaces it.
- R11: A new `cfgMode` value takes effect only in a cycle where both the transmitter and the receiver are idle. During a frame the old mode stays in force.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cfgMode | input | 2 | Requested line mode |
| txData | input | DATA_BITS | Byte to transmit |
| txValid | input | 1 | Transmit byte offered |
| txReady | output | 1 | Transmitter idle and able to take a byte |
| lineTx | output | 1 | Coded line, or raw bit in pass-through mode |
| lineTxN | output | 1 | Complement driver in differential mode, low otherwise |
| txEnable | output | 1 | External transceiver enable in single-ended mode |
| bitClk | output | 1 | Pass-through bit clock |
| frameClk | output | 1 | Pass-through frame clock |
| lineRx | input | 1 | Receive line, or positive leg of the receive pair |
| lineRxN | input | 1 | Negative receive leg, or frame marker in pass-through mode |
| rxData | output | DATA_BITS | Received byte |
| rxValid | output | 1 | Received byte available |
| rxReady | input | 1 | Consumer takes the received byte |
| codeViolation | output | 1 | One-cycle pulse on a missing cell boundary |

## Verification
The bench builds the port with `CELL_CYCLES = 8` and `DATA_BITS = 8`. Eight cycles is the smallest cell for which, after the two-register receive delay, a loopback mid-cell change lands inside the mid window and a boundary change lands beyond it. This makes the window edges of the decoder and the violation limit reachable in a few cycles. Ten-cell frames keep each byte near eighty cycles. That leaves room to loop the transmitter back into the receiver in every mode, to change the mode in the middle of a frame, to hold an unread byte while a second one arrives, and to drive lone line changes from the bench that starve the decoder of boundaries.

// File: rtl/linePortPkg.sv
package linePortPkg;

  typedef enum logic [1:0] {
    MODE_SE       = 2'd0,
    MODE_RAW      = 2'd1,
    MODE_DIFF     = 2'd2,
    MODE_DIFF_ALT = 2'd3
  } mode_e;

  typedef struct packed {
    logic txLoad;        // byte captured this edge
    logic txCellEnd;     // last cycle of a data cell
    logic txCellBegin;   // first cycle of a data cell
    logic txInData;      // inside a data cell
    logic txSecondHalf;  // cell counter in second half
    logic txFirstCell;   // current data cell is the MSB
    logic txBusy;        // lead, data or trail cell
    logic rxStart;       // receiver leaves hunt
    logic rxTake;        // shift one received bit in
    logic rxDone;        // last bit of the byte taken
    logic rxInMid;       // receive counter inside mid-cell window
  } ctrlStrobe_t;

endpackage

// File: rtl/linePortCtrl.sv
module linePortCtrl
  import linePortPkg::*;
#(
  parameter int CELL_CYCLES = 8,
  parameter int DATA_BITS   = 8
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [1:0]  cfgMode,
  input  logic        txValid,
  input  logic        rxEdge,
  output logic        txReady,
  output mode_e       modeQ,
  output ctrlStrobe_t strb,
  output logic        codeViolation
);
  localparam int HALF  = CELL_CYCLES / 2;
  localparam int QTR   = CELL_CYCLES / 4;
  localparam int LIMIT = CELL_CYCLES + QTR;
  localparam int TW    = $clog2(CELL_CYCLES);
  localparam int CW    = $clog2(LIMIT + 1);
  localparam int BW    = $clog2(DATA_BITS);
  localparam logic [TW-1:0] TX_LAST  = TW'(CELL_CYCLES - 1);
  localparam logic [TW-1:0] TX_HALF  = TW'(HALF);
  localparam logic [CW-1:0] RX_QTR   = CW'(QTR);
  localparam logic [CW-1:0] RX_DEC   = CW'(3 * QTR);
  localparam logic [CW-1:0] RX_RAWS  = CW'(HALF - 1);
  localparam logic [CW-1:0] RX_WRAP  = CW'(CELL_CYCLES - 1);
  localparam logic [CW-1:0] RX_LIMIT = CW'(LIMIT);
  localparam logic [BW-1:0] LAST_BIT = BW'(DATA_BITS - 1);

  typedef enum logic [1:0] {TX_IDLE, TX_LEAD, TX_DATA, TX_TRAIL} txPhase_e;

  txPhase_e      txPhase;
  logic [TW-1:0] txCnt;
  logic [BW-1:0] txBitIdx;
  logic          rxBusy;
  logic [CW-1:0] rxCnt;
  logic [BW-1:0] rxNum;
  logic          isRaw, txLast, rxBoundary, rxWrap;

  assign isRaw   = (modeQ == MODE_RAW);
  assign txLast  = (txCnt == TX_LAST);
  assign txReady = (txPhase == TX_IDLE);

  always_comb begin
    strb              = '0;
    strb.txLoad       = txReady && txValid;
    strb.txInData     = (txPhase == TX_DATA);
    strb.txCellEnd    = strb.txInData && txLast;
    strb.txCellBegin  = strb.txInData && (txCnt == '0);
    strb.txSecondHalf = (txCnt >= TX_HALF);
    strb.txFirstCell  = (txBitIdx == '0);
    strb.txBusy       = !txReady;
    strb.rxStart      = !rxBusy && rxEdge;
    strb.rxTake       = rxBusy && (isRaw ? (rxCnt == RX_RAWS) : (rxCnt == RX_DEC));
    strb.rxDone       = strb.rxTake && (rxNum == LAST_BIT);
    strb.rxInMid      = rxBusy && (rxCnt >= RX_QTR) && (rxCnt < RX_DEC);
  end

  assign rxBoundary    = rxBusy && !isRaw && rxEdge && (rxCnt > RX_DEC);
  assign rxWrap        = isRaw && (rxCnt == RX_WRAP);
  assign codeViolation = rxBusy && !isRaw && (rxCnt == RX_LIMIT) && !rxEdge;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txPhase  <= TX_IDLE;
      txCnt    <= '0;
      txBitIdx <= '0;
    end else if (txPhase == TX_IDLE) begin
      if (txValid) begin
        txPhase <= TX_LEAD;
        txCnt   <= '0;
      end
    end else if (txLast) begin
      txCnt <= '0;
      case (txPhase)
        TX_LEAD: begin
          txPhase  <= TX_DATA;
          txBitIdx <= '0;
        end
        TX_DATA: begin
          if (txBitIdx == LAST_BIT) txPhase <= TX_TRAIL;
          else txBitIdx <= txBitIdx + 1'b1;
        end
        default: txPhase <= TX_IDLE;
      endcase
    end else begin
      txCnt <= txCnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) modeQ <= MODE_SE;
    else if (txReady && !rxBusy) modeQ <= mode_e'(cfgMode);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxBusy <= 1'b0;
      rxCnt  <= '0;
      rxNum  <= '0;
    end else if (strb.rxStart) begin
      rxBusy <= 1'b1;
      rxCnt  <= '0;
      rxNum  <= '0;
    end else if (rxBusy) begin
      if (strb.rxDone || codeViolation) begin
        rxBusy <= 1'b0;
      end else begin
        if (strb.rxTake) rxNum <= rxNum + 1'b1;
        if (rxBoundary || rxWrap) rxCnt <= '0;
        else rxCnt <= rxCnt + 1'b1;
      end
    end
  end

  // R3: an accepted byte closes the transmit handshake for the next cycle
  a_r3_accept_closes_ready: assert property (@(posedge clk) disable iff (!rstN)
    (txValid && txReady) |=> !txReady);

  // R11: no mode change while either direction is active
  a_r11_mode_frozen: assert property (@(posedge clk) disable iff (!rstN)
    (strb.txBusy || rxBusy) |=> $stable(modeQ));

  // R9: a violation always leaves the receiver idle
  a_r9_violation_ends_byte: assert property (@(posedge clk) disable iff (!rstN)
    codeViolation |=> !rxBusy);

endmodule

// File: rtl/linePortPath.sv
module linePortPath
  import linePortPkg::*;
#(
  parameter int DATA_BITS = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  mode_e                modeQ,
  input  ctrlStrobe_t          strb,
  input  logic [DATA_BITS-1:0] txData,
  input  logic                 lineRx,
  input  logic                 lineRxN,
  input  logic                 rxReady,
  output logic                 lineTx,
  output logic                 lineTxN,
  output logic                 txEnable,
  output logic                 bitClk,
  output logic                 frameClk,
  output logic                 rxEdge,
  output logic [DATA_BITS-1:0] rxData,
  output logic                 rxValid
);
  logic [DATA_BITS-1:0] txSh, rxSh;
  logic lvl, curBit, cellLevel, coded;
  logic isRaw, isDiff, isSe;
  logic rxS, prevS, rxM, prevM, rxIn, midSeen, rxBit;

  assign isRaw  = (modeQ == MODE_RAW);
  assign isSe   = (modeQ == MODE_SE);
  assign isDiff = (modeQ == MODE_DIFF) || (modeQ == MODE_DIFF_ALT);

  assign curBit    = txSh[DATA_BITS-1];
  assign cellLevel = lvl ^ 1'b1 ^ (~curBit & strb.txSecondHalf);
  assign coded     = strb.txInData ? cellLevel : lvl;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txSh <= '0;
      lvl  <= 1'b0;
    end else begin
      if (strb.txLoad) txSh <= txData;
      else if (strb.txCellEnd) txSh <= {txSh[DATA_BITS-2:0], 1'b0};
      if (strb.txCellEnd && !isRaw) lvl <= cellLevel;
    end
  end

  always_comb begin
    lineTx   = coded;
    lineTxN  = 1'b0;
    txEnable = 1'b0;
    bitClk   = 1'b0;
    frameClk = 1'b0;
    if (isRaw) begin
      lineTx   = strb.txInData & curBit;
      bitClk   = strb.txInData & ~strb.txSecondHalf;
      frameClk = strb.txInData & strb.txFirstCell;
    end else if (isSe) begin
      txEnable = strb.txBusy;
    end else begin
      lineTxN = ~coded;
    end
  end

  assign rxIn   = (isDiff && (lineRx == lineRxN)) ? rxS : lineRx;
  assign rxEdge = isRaw ? (rxM & ~prevM) : (rxS ^ prevS);
  assign rxBit  = isRaw ? rxS : ~midSeen;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxS     <= 1'b0;
      prevS   <= 1'b0;
      rxM     <= 1'b0;
      prevM   <= 1'b0;
      midSeen <= 1'b0;
      rxSh    <= '0;
      rxData  <= '0;
      rxValid <= 1'b0;
    end else begin
      rxS   <= rxIn;
      prevS <= rxS;
      rxM   <= lineRxN;
      prevM <= rxM;
      if (strb.rxStart || strb.rxTake) midSeen <= 1'b0;
      else if (rxEdge && strb.rxInMid) midSeen <= 1'b1;
      if (strb.rxTake) rxSh <= {rxSh[DATA_BITS-2:0], rxBit};
      if (strb.rxDone) begin
        rxData  <= {rxSh[DATA_BITS-2:0], rxBit};
        rxValid <= 1'b1;
      end else if (rxReady) begin
        rxValid <= 1'b0;
      end
    end
  end

  // R2: every coded data cell opens with a level change
  a_r2_boundary_toggle: assert property (@(posedge clk) disable iff (!rstN)
    (strb.txCellBegin && !isRaw) |-> (coded != $past(coded)));

  // R4: the transceiver is already enabled when the first bit starts
  a_r4_enable_leads: assert property (@(posedge clk) disable iff (!rstN)
    (strb.txCellBegin && strb.txFirstCell && isSe) |-> $past(txEnable));

  // R10: an unread byte stays offered
  a_r10_valid_held: assert property (@(posedge clk) disable iff (!rstN)
    (rxValid && !rxReady) |=> rxValid);

endmodule

// File: rtl/linePort.sv
module linePort
  import linePortPkg::*;
#(
  parameter int CELL_CYCLES = 8,
  parameter int DATA_BITS   = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [1:0]           cfgMode,
  input  logic [DATA_BITS-1:0] txData,
  input  logic                 txValid,
  output logic                 txReady,
  output logic                 lineTx,
  output logic                 lineTxN,
  output logic                 txEnable,
  output logic                 bitClk,
  output logic                 frameClk,
  input  logic                 lineRx,
  input  logic                 lineRxN,
  output logic [DATA_BITS-1:0] rxData,
  output logic                 rxValid,
  input  logic                 rxReady,
  output logic                 codeViolation
);
  mode_e       modeQ;
  ctrlStrobe_t strb;
  logic        rxEdge;

  linePortCtrl #(.CELL_CYCLES(CELL_CYCLES), .DATA_BITS(DATA_BITS)) uCtrl (
    .clk(clk), .rstN(rstN), .cfgMode(cfgMode), .txValid(txValid),
    .rxEdge(rxEdge), .txReady(txReady), .modeQ(modeQ), .strb(strb),
    .codeViolation(codeViolation)
  );

  linePortPath #(.DATA_BITS(DATA_BITS)) uPath (
    .clk(clk), .rstN(rstN), .modeQ(modeQ), .strb(strb), .txData(txData),
    .lineRx(lineRx), .lineRxN(lineRxN), .rxReady(rxReady),
    .lineTx(lineTx), .lineTxN(lineTxN), .txEnable(txEnable),
    .bitClk(bitClk), .frameClk(frameClk), .rxEdge(rxEdge),
    .rxData(rxData), .rxValid(rxValid)
  );

endmodule

// File: tb/tb_linePort.sv
module tb_linePort;
  localparam int CLK_PERIOD = 10;
  localparam int CELL = 8;
  localparam int DW = 8;
  localparam int FRAME = (DW + 2) * CELL;

  logic clk = 1'b0, rstN = 1'b0;
  logic [1:0] cfgMode = 2'd0;
  logic [DW-1:0] txData = '0;
  logic txValid = 1'b0, rxReady = 1'b1;
  logic txReady, lineTx, lineTxN, txEnable, bitClk, frameClk;
  logic [DW-1:0] rxData;
  logic rxValid, codeViolation;
  logic loop = 1'b1, drvRx = 1'b0, drvN = 1'b0;
  logic lineRxIn, lineRxNIn;

  logic [1:0] mMode = 2'd0;
  int t = -1;
  logic [DW-1:0] mByte = '0;
  logic mLvl = 1'b0;
  logic [DW-1:0] lastByte = '0;
  int vectors = 0, fails = 0, rxHs = 0, violCnt = 0;
  bit running = 1'b0, finished = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  assign lineRxIn  = loop ? lineTx : drvRx;
  assign lineRxNIn = loop ? ((mMode == 2'd1) ? frameClk : lineTxN) : drvN;

  linePort #(.CELL_CYCLES(CELL), .DATA_BITS(DW)) dut (
    .clk(clk), .rstN(rstN), .cfgMode(cfgMode), .txData(txData),
    .txValid(txValid), .txReady(txReady), .lineTx(lineTx), .lineTxN(lineTxN),
    .txEnable(txEnable), .bitClk(bitClk), .frameClk(frameClk),
    .lineRx(lineRxIn), .lineRxN(lineRxNIn), .rxData(rxData),
    .rxValid(rxValid), .rxReady(rxReady), .codeViolation(codeViolation)
  );

  function automatic logic frameLevel(int tt);
    logic lev;
    lev = mLvl;
    if (tt < 0) return mLvl;
    for (int j = 0; j < DW; j++) begin
      int st;
      logic nb;
      st = CELL * (1 + j);
      nb = ~mByte[DW-1-j];
      if (tt < st) return lev;
      if (tt < st + CELL) return lev ^ 1'b1 ^ (nb && ((tt - st) >= CELL / 2));
      lev = lev ^ 1'b1 ^ nb;
    end
    return lev;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural model of the transmit timeline and the applied mode
  always @(posedge clk) begin
    if (!rstN) begin
      t = -1; mLvl = 1'b0; mMode <= 2'd0;
    end else if (t < 0) begin
      mMode <= cfgMode;
      if (txValid) begin t = 0; mByte = txData; end
    end else begin
      t++;
      if (t == FRAME) begin
        if (mMode != 2'd1) mLvl = frameLevel(FRAME - 1);
        t = -1;
      end
    end
  end

  // compare every cycle away from the active edge
  always @(negedge clk) begin
    if (rstN && running) begin
      logic busy, inData, eTx, eN, eEn, eBc, eFc, lv;
      int c, idx;
      string req;
      busy = (t >= 0);
      inData = busy && t >= CELL && t < (DW + 1) * CELL;
      c = busy ? t % CELL : 0;
      idx = inData ? (t - CELL) / CELL : 0;
      lv = frameLevel(t);
      eBc = 1'b0; eFc = 1'b0; eN = 1'b0; eEn = 1'b0; eTx = lv;
      case (mMode)
        2'd0: begin eEn = busy; req = "R2 R3 R4 R11"; end
        2'd1: begin
          eTx = inData ? mByte[DW-1-idx] : 1'b0;
          eBc = inData && (c < CELL / 2);
          eFc = inData && (idx == 0);
          req = "R3 R6 R11";
        end
        default: begin eN = ~lv; req = "R1 R2 R3 R5 R11"; end
      endcase
      check(req, {txReady, lineTx, lineTxN, txEnable, bitClk, frameClk},
            {~busy, eTx, eN, eEn, eBc, eFc});
      if (rxValid && rxReady) begin
        rxHs++;
        check((mMode == 2'd1) ? "R8 rx byte" : "R7 rx byte", rxData, lastByte);
      end
      if (codeViolation) violCnt++;
    end
  end

  task automatic sendByte(input logic [DW-1:0] b);
    @(negedge clk);
    while (!txReady) @(negedge clk);
    txData = b; txValid = 1'b1; lastByte = b;
    @(posedge clk);
    #1 txValid = 1'b0;
    @(negedge clk);
    while (!txReady) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    vectors++; fails++;
    $display("FAIL R3 watchdog actual=hung expected=finished");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R3: reset state
    check("R3 reset txReady", txReady, 1);
    check("R3 reset lineTx", lineTx, 0);
    check("R4 reset txEnable", txEnable, 0);
    check("R10 reset rxValid", rxValid, 0);
    rstN = 1'b1;
    running = 1'b1;
    repeat (3) @(negedge clk);

    // R1 single-ended line-coded, various patterns
    sendByte(8'hA5);
    sendByte(8'h00);
    sendByte(8'hFF);

    // R11: mode request during a frame is deferred
    @(negedge clk);
    txData = 8'h3C; txValid = 1'b1; lastByte = 8'h3C;
    @(posedge clk);
    #1 txValid = 1'b0;
    repeat (3 * CELL) @(negedge clk);
    cfgMode = 2'd2;
    @(negedge clk);
    check("R11 old mode enable kept", txEnable, 1);
    check("R11 old mode no complement", lineTxN, 0);
    while (!txReady) @(negedge clk);
    repeat (4) @(negedge clk);

    // R5 differential, both encodings of R1
    sendByte(8'h96);
    cfgMode = 2'd3;
    repeat (2) @(negedge clk);
    sendByte(8'h03);

    // R6 R8 pass-through
    cfgMode = 2'd1;
    repeat (2) @(negedge clk);
    sendByte(8'hC3);
    sendByte(8'h5A);

    // R10: unread byte replaced by a newer one
    rxReady = 1'b0;
    sendByte(8'h11);
    sendByte(8'h22);
    check("R10 valid held", rxValid, 1);
    check("R10 newest byte kept", rxData, 8'h22);
    rxReady = 1'b1;
    repeat (2) @(negedge clk);
    check("R10 valid cleared after read", rxValid, 0);

    // R9: lone line changes starve the decoder of boundaries
    cfgMode = 2'd0;
    repeat (4) @(negedge clk);
    drvRx = 1'b0; drvN = 1'b0; loop = 1'b0;
    repeat (2) @(negedge clk);
    drvRx = 1'b1;
    repeat (3 * CELL) @(negedge clk);
    drvRx = 1'b0;
    repeat (3 * CELL) @(negedge clk);
    check("R9 violation pulses", violCnt, 2);
    check("R9 partial byte discarded", rxValid, 0);
    loop = 1'b1;
    repeat (4) @(negedge clk);
    sendByte(8'h81);

    check("R7 R8 R10 delivered byte count", rxHs, 10);
    check("R9 no violation in good traffic", violCnt, 2);
    finishRun();
  end
endmodule